// File: doc/BRIEF.md
# Privileged Address Segment Translator

This block turns a 32-bit virtual address into a physical address for a load or a store. It uses fixed address segments and the privilege mode the processor is running in. For each request it decides one of three outcomes. The address may fall in a direct window that needs no translation. It may need a page-table lookup, which an external TLB answers in the same cycle. Or the current mode may not touch it, which makes it an address error. When the error-level flag is set, the low half of the address space bypasses translation.

The response is registered and appears one cycle after the request. It carries the physical address, a fault flag, a three-bit fault class and a refill hint. The exception unit uses the refill hint to pick the refill vector. On a fault the block also captures the register values the exception logic must load: the faulting address, the updated context word (page-number field replaced, other bits kept) and the new entry-high word (page number plus the current address-space ID).

Top module: `privseg_xlate`

## Requirements
- R1: With the error-level flag clear, addresses 0x00000000–0x7FFFFFFF are legal in every mode and translated through the TLB. `tlb_lookup` is high in the request cycle exactly when a legal request needs translation. On a TLB hit the response physical address is `tlb_phys`.
- R2: With the error-level flag set, addresses 0x00000000–0x7FFFFFFF pass through with physical = virtual. No lookup is issued and the TLB result is ignored.
- R3: Addresses 0x80000000–0xBFFFFFFF are legal only in kernel mode and are untranslated. The physical address is the virtual address with bits 31:29 cleared.
- R4: Addresses 0xC0000000–0xDFFFFFFF are translated and legal in supervisor or kernel mode.
- R5: Addresses 0xE0000000–0xFFFFFFFF are translated and legal only in kernel mode.
- R6: Mode encoding is 00 user, 01 supervisor, 10 and 11 kernel. An illegal access faults with code 1 for a read and code 2 for a write. It takes precedence over any TLB result.
- R7: TLB result encoding is 0 hit, 1 no match, 2 invalid, 3 modify. No match and invalid fault with code 3 on reads and code 4 on writes. Modify faults with code 5. The refill flag is set only for no match.
- R8: The response is registered: `rsp_valid` is high exactly one cycle after `req_valid`. A faulting response has `rsp_phys` = 0. A clean response has fault, code 0 and refill low. After reset all outputs are 0.
- R9: On a fault, `bad_vaddr` takes the address. `ctx_val` takes the context input with bits 22:4 replaced by address bits 31:13. `entryhi_val` takes the address with bits 12:0 cleared, ORed with the 8-bit ASID. All three hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Privilege mode |
| err_level | input | 1 | Error-level status flag |
| cur_asid | input | 8 | Current address-space ID |
| ctx_in | input | 32 | Current context register value |
| tlb_lookup | output | 1 | TLB lookup request (combinational) |
| tlb_vaddr | output | 32 | Address presented to the TLB |
| tlb_write | output | 1 | Access kind presented to the TLB |
| tlb_result | input | 2 | TLB outcome |
| tlb_phys | input | 32 | TLB physical address on hit |
| rsp_valid | output | 1 | Response strobe |
| rsp_phys | output | 32 | Physical address |
| rsp_fault | output | 1 | Fault flag |
| rsp_code | output | 3 | Fault class |
| rsp_refill | output | 1 | No-match refill hint |
| bad_vaddr | output | 32 | Captured faulting address |
| ctx_val | output | 32 | Captured context update |
| entryhi_val | output | 32 | Captured entry-high update |

## Verification
Two sources of fault can meet in one cycle: the segment legality check and the TLB result. Some vectors make an illegal access while the TLB reports no match. The bench expects only the address-error class, with no refill hint. Other vectors set the error-level flag while the TLB reports a failure. The bench expects a clean pass-through. In each case it also checks that the captured fault words hold from the earlier fault.

// File: rtl/privseg_pkg.sv
// Shared types for the privileged address segment translator.
package privseg_pkg;

    // Fault classes reported on rsp_code.
    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_ADDR_RD  = 3'd1,
        FC_ADDR_WR  = 3'd2,
        FC_TLB_RD   = 3'd3,
        FC_TLB_WR   = 3'd4,
        FC_TLB_MOD  = 3'd5
    } fault_code_e;

    // Outcome reported by the external TLB.
    typedef enum logic [1:0] {
        TR_HIT     = 2'd0,
        TR_NOMATCH = 2'd1,
        TR_INVALID = 2'd2,
        TR_MODIFY  = 2'd3
    } tlb_res_e;

endpackage

// File: rtl/privseg_classify.sv
// Segment classifier.
// Decides from the top address bits, the mode and the error-level flag
// whether an access is legal, whether it needs translation, and the
// physical address of the untranslated windows.
// Assumes mode 00 = user, 01 = supervisor, 1x = kernel.
module privseg_classify #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    mode,
    input  logic          err_level,
    output logic          legal,
    output logic          mapped,
    output logic [AW-1:0] direct_phys
);
    localparam int WIN_LSB = AW - 3;

    logic is_kernel;
    logic is_super;
    logic [2:0] seg;

    assign is_kernel = mode[1];
    assign is_super  = (mode == 2'b01);
    assign seg       = addr[AW-1:WIN_LSB];

    // Segment decode: legality, translation need and window address.
    always_comb begin
        legal       = 1'b0;
        mapped      = 1'b0;
        direct_phys = '0;
        if (!seg[2]) begin
            legal = 1'b1;
            if (err_level) begin
                direct_phys = addr;
            end else begin
                mapped = 1'b1;
            end
        end else if (seg[2:1] == 2'b10) begin
            legal       = is_kernel;
            direct_phys = {3'b000, addr[WIN_LSB-1:0]};
        end else if (seg == 3'b110) begin
            legal  = is_kernel | is_super;
            mapped = 1'b1;
        end else begin
            legal  = is_kernel;
            mapped = 1'b1;
        end
    end

    // R2: error level keeps the low half out of translation
    a_r2_erl_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && err_level && !addr[AW-1]) |-> (legal && !mapped));

    // R6: user mode never reaches the upper half
    a_r6_user_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b00 && addr[AW-1]) |-> !legal);
endmodule

// File: rtl/privseg_fault.sv
// Fault encoder.
// Combines segment legality with the TLB outcome into a fault class and
// refill hint, and forms the context and entry-high update words.
// Assumes the TLB outcome is meaningful only when the access is mapped.
module privseg_fault
    import privseg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ASID_W     = 8,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_LSB    = 4
) (
    input  logic              legal,
    input  logic              mapped,
    input  logic              write,
    input  logic [1:0]        tlb_result,
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     ctx_in,
    input  logic [ASID_W-1:0] asid,
    output logic              fault,
    output logic [2:0]        code,
    output logic              refill,
    output logic [AW-1:0]     ctx_next,
    output logic [AW-1:0]     eh_next
);
    localparam int VPN_W   = AW - PAGE_SHIFT;
    localparam int CTX_MSB = CTX_LSB + VPN_W - 1;
    localparam int GAP_W   = PAGE_SHIFT - ASID_W;

    tlb_res_e    res;
    fault_code_e fc;

    assign res = tlb_res_e'(tlb_result);

    // Fault priority: segment legality first, then the TLB outcome.
    always_comb begin
        fc     = FC_NONE;
        refill = 1'b0;
        if (!legal) begin
            fc = write ? FC_ADDR_WR : FC_ADDR_RD;
        end else if (mapped) begin
            unique case (res)
                TR_HIT:     fc = FC_NONE;
                TR_NOMATCH: begin
                    fc     = write ? FC_TLB_WR : FC_TLB_RD;
                    refill = 1'b1;
                end
                TR_INVALID: fc = write ? FC_TLB_WR : FC_TLB_RD;
                TR_MODIFY:  fc = FC_TLB_MOD;
                default:    fc = FC_NONE;
            endcase
        end
    end

    assign code  = fc;
    assign fault = (fc != FC_NONE);

    // Context update: page number lands in the field, rest preserved.
    always_comb begin
        ctx_next = ctx_in;
        ctx_next[CTX_MSB:CTX_LSB] = addr[AW-1:PAGE_SHIFT];
    end

    // Entry-high update: page number with ASID in the low bits.
    generate
        if (GAP_W > 0) begin : g_gap
            assign eh_next = {addr[AW-1:PAGE_SHIFT], {GAP_W{1'b0}}, asid};
        end else begin : g_nogap
            assign eh_next = {addr[AW-1:PAGE_SHIFT], asid};
        end
    endgenerate

    // R7: refill hint only accompanies a TLB read/write fault
    a_r7_refill_class: assert final (!refill || fc == FC_TLB_RD || fc == FC_TLB_WR);
endmodule

// File: rtl/privseg_xlate.sv
// Privileged address segment translator, top level.
// Accepts one request per cycle, consults the external TLB in the same
// cycle when translation is needed, and registers the response together
// with the exception register update values captured on a fault.
// Assumes the TLB answers combinationally.
module privseg_xlate
    import privseg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ASID_W     = 8,
    parameter int PAGE_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic              err_level,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [AW-1:0]     ctx_in,
    output logic              tlb_lookup,
    output logic [AW-1:0]     tlb_vaddr,
    output logic              tlb_write,
    input  logic [1:0]        tlb_result,
    input  logic [AW-1:0]     tlb_phys,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_phys,
    output logic              rsp_fault,
    output logic [2:0]        rsp_code,
    output logic              rsp_refill,
    output logic [AW-1:0]     bad_vaddr,
    output logic [AW-1:0]     ctx_val,
    output logic [AW-1:0]     entryhi_val
);
    logic          legal;
    logic          mapped;
    logic [AW-1:0] direct_phys;
    logic          fault;
    logic [2:0]    code;
    logic          refill;
    logic [AW-1:0] ctx_next;
    logic [AW-1:0] eh_next;
    logic [AW-1:0] phys_next;

    privseg_classify #(.AW(AW)) u_classify (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .addr        (req_addr),
        .mode        (req_mode),
        .err_level   (err_level),
        .legal       (legal),
        .mapped      (mapped),
        .direct_phys (direct_phys)
    );

    privseg_fault #(
        .AW(AW), .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_fault (
        .legal      (legal),
        .mapped     (mapped),
        .write      (req_write),
        .tlb_result (tlb_result),
        .addr       (req_addr),
        .ctx_in     (ctx_in),
        .asid       (cur_asid),
        .fault      (fault),
        .code       (code),
        .refill     (refill),
        .ctx_next   (ctx_next),
        .eh_next    (eh_next)
    );

    assign tlb_lookup = req_valid & legal & mapped;
    assign tlb_vaddr  = req_addr;
    assign tlb_write  = req_write;

    // Physical address selection; zero on a fault.
    always_comb begin
        if (fault)       phys_next = '0;
        else if (mapped) phys_next = tlb_phys;
        else             phys_next = direct_phys;
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_phys   <= '0;
            rsp_fault  <= 1'b0;
            rsp_code   <= 3'd0;
            rsp_refill <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_phys   <= req_valid ? phys_next : '0;
            rsp_fault  <= req_valid & fault;
            rsp_code   <= req_valid ? code : 3'd0;
            rsp_refill <= req_valid & refill;
        end
    end

    // Exception register update capture, loaded only on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_vaddr   <= '0;
            ctx_val     <= '0;
            entryhi_val <= '0;
        end else if (req_valid && fault) begin
            bad_vaddr   <= req_addr;
            ctx_val     <= ctx_next;
            entryhi_val <= eh_next;
        end
    end

    // R8: response follows request by one cycle
    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: faulting response carries a zero address
    a_r8_fault_phys: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_phys == '0 && rsp_valid));

    // R9: captured words hold when no fault is reported
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> ($stable(bad_vaddr) && $stable(entryhi_val)));

    // R3: clean direct-window response has a cleared top field
    a_r3_window_top: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && $past(req_addr[AW-1:AW-2]) == 2'b10)
        |-> rsp_phys[AW-1:AW-3] == 3'b000);
endmodule

// File: tb/privseg_xlate_tb.sv
module privseg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = '0;
    logic        err_level = 1'b0;
    logic [7:0]  cur_asid = 8'h3C;
    logic [31:0] ctx_in = 32'hA5A5A5A5;
    logic        tlb_lookup;
    logic [31:0] tlb_vaddr;
    logic        tlb_write;
    logic [1:0]  tlb_result = '0;
    logic [31:0] tlb_phys = '0;
    logic        rsp_valid;
    logic [31:0] rsp_phys;
    logic        rsp_fault;
    logic [2:0]  rsp_code;
    logic        rsp_refill;
    logic [31:0] bad_vaddr;
    logic [31:0] ctx_val;
    logic [31:0] entryhi_val;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    privseg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_mode(req_mode), .err_level(err_level),
        .cur_asid(cur_asid), .ctx_in(ctx_in), .tlb_lookup(tlb_lookup),
        .tlb_vaddr(tlb_vaddr), .tlb_write(tlb_write), .tlb_result(tlb_result),
        .tlb_phys(tlb_phys), .rsp_valid(rsp_valid), .rsp_phys(rsp_phys),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_refill(rsp_refill),
        .bad_vaddr(bad_vaddr), .ctx_val(ctx_val), .entryhi_val(entryhi_val)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  mode;
        logic        erl;
        logic [1:0]  tres;
        logic [31:0] tphys;
        logic        e_look;
        logic [2:0]  e_code;
        logic        e_refill;
        logic [31:0] e_phys;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R1 user translated hit
        '{32'h00401234, 1'b0, 2'd0, 1'b0, 2'd0, 32'h12345234, 1'b1, 3'd0, 1'b0, 32'h12345234},
        // R2 error level pass-through, TLB failure ignored
        '{32'h00401234, 1'b1, 2'd0, 1'b1, 2'd1, 32'hDEADBEEF, 1'b0, 3'd0, 1'b0, 32'h00401234},
        // R3 cached window kernel
        '{32'h80001000, 1'b0, 2'd2, 1'b0, 2'd1, 32'h0, 1'b0, 3'd0, 1'b0, 32'h00001000},
        // R6 user into kernel window read
        '{32'h80001000, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0, 1'b0, 3'd1, 1'b0, 32'h0},
        // R3 uncached window kernel write
        '{32'hA1234568, 1'b1, 2'd2, 1'b0, 2'd0, 32'h0, 1'b0, 3'd0, 1'b0, 32'h01234568},
        // R6 supervisor into uncached window write
        '{32'hBFC00000, 1'b1, 2'd1, 1'b0, 2'd0, 32'h0, 1'b0, 3'd2, 1'b0, 32'h0},
        // R4 supervisor segment hit
        '{32'hC0000010, 1'b0, 2'd1, 1'b0, 2'd0, 32'h20000010, 1'b1, 3'd0, 1'b0, 32'h20000010},
        // R4 R6 user into supervisor segment, TLB no-match loses
        '{32'hC0000010, 1'b1, 2'd0, 1'b0, 2'd1, 32'h0, 1'b0, 3'd2, 1'b0, 32'h0},
        // R5 kernel top segment hit
        '{32'hE0000000, 1'b0, 2'd2, 1'b0, 2'd0, 32'h00000003, 1'b1, 3'd0, 1'b0, 32'h00000003},
        // R5 supervisor into top segment
        '{32'hE0000000, 1'b0, 2'd1, 1'b0, 2'd0, 32'h0, 1'b0, 3'd1, 1'b0, 32'h0},
        // R7 no-match read refill
        '{32'h00002000, 1'b0, 2'd0, 1'b0, 2'd1, 32'h0, 1'b1, 3'd3, 1'b1, 32'h0},
        // R7 no-match write refill
        '{32'h00002000, 1'b1, 2'd2, 1'b0, 2'd1, 32'h0, 1'b1, 3'd4, 1'b1, 32'h0},
        // R7 invalid read
        '{32'h7FFFF000, 1'b0, 2'd1, 1'b0, 2'd2, 32'h0, 1'b1, 3'd3, 1'b0, 32'h0},
        // R7 invalid write
        '{32'h7FFFF000, 1'b1, 2'd1, 1'b0, 2'd2, 32'h0, 1'b1, 3'd4, 1'b0, 32'h0},
        // R7 modify
        '{32'h12345000, 1'b1, 2'd2, 1'b0, 2'd3, 32'h0, 1'b1, 3'd5, 1'b0, 32'h0},
        // R3 window upper edge
        '{32'h9FFFFFFF, 1'b1, 2'd2, 1'b0, 2'd0, 32'h0, 1'b0, 3'd0, 1'b0, 32'h1FFFFFFF},
        // R6 mode 11 is kernel
        '{32'hE0000000, 1'b0, 2'd3, 1'b0, 2'd0, 32'h00000040, 1'b1, 3'd0, 1'b0, 32'h00000040}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] exp_bad;
        logic [31:0] exp_ctx;
        logic [31:0] exp_eh;
        exp_bad = '0; exp_ctx = '0; exp_eh = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        chk("R8 reset valid", {31'b0, rsp_valid}, 32'd0);
        chk("R8 reset fault", {31'b0, rsp_fault}, 32'd0);
        chk("R9 reset badvaddr", bad_vaddr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            req_valid  = 1'b1;
            req_addr   = VECS[i].addr;
            req_write  = VECS[i].wr;
            req_mode   = VECS[i].mode;
            err_level  = VECS[i].erl;
            tlb_result = VECS[i].tres;
            tlb_phys   = VECS[i].tphys;
            #1;
            chk($sformatf("R1 lookup v%0d", i), {31'b0, tlb_lookup}, {31'b0, VECS[i].e_look});
            @(negedge clk);
            req_valid = 1'b0;
            chk($sformatf("R8 valid v%0d", i), {31'b0, rsp_valid}, 32'd1);
            chk($sformatf("R6 R7 code v%0d", i), {29'b0, rsp_code}, {29'b0, VECS[i].e_code});
            chk($sformatf("R8 fault v%0d", i), {31'b0, rsp_fault}, {31'b0, VECS[i].e_code != 3'd0});
            chk($sformatf("R7 refill v%0d", i), {31'b0, rsp_refill}, {31'b0, VECS[i].e_refill});
            chk($sformatf("R1 R3 phys v%0d", i), rsp_phys, VECS[i].e_phys);
            if (VECS[i].e_code != 3'd0) begin
                exp_bad = VECS[i].addr;
                exp_ctx = (ctx_in & ~32'h007FFFF0) | ((VECS[i].addr >> 9) & 32'h007FFFF0);
                exp_eh  = (VECS[i].addr & 32'hFFFFE000) | {24'b0, cur_asid};
            end
            chk($sformatf("R9 badvaddr v%0d", i), bad_vaddr, exp_bad);
            chk($sformatf("R9 context v%0d", i), ctx_val, exp_ctx);
            chk($sformatf("R9 entryhi v%0d", i), entryhi_val, exp_eh);
        end

        // R8 idle cycle: no response, captured words hold
        @(negedge clk);
        chk("R8 idle valid", {31'b0, rsp_valid}, 32'd0);
        chk("R9 idle hold", entryhi_val, exp_eh);

        // R9 different ASID and context, kernel top segment from user
        cur_asid = 8'h81;
        ctx_in   = 32'hFFFFFFFF;
        req_valid = 1'b1; req_addr = 32'hFFFFFFFF; req_write = 1'b0;
        req_mode = 2'd0; err_level = 1'b0; tlb_result = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 top user code", {29'b0, rsp_code}, 32'd1);
        chk("R9 context all ones", ctx_val, (32'hFFFFFFFF & ~32'h007FFFF0) | ((32'hFFFFFFFF >> 9) & 32'h007FFFF0));
        chk("R9 entryhi asid", entryhi_val, 32'hFFFFE081);

        // R8 reset mid-run clears response
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset entryhi", entryhi_val, 32'd0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule